// File: doc/BRIEF.md
# Wake Sleep Timer

A 16-bit free-running counter for an always-on domain. It counts enable pulses taken from one of two slow time bases, a calibrated 1 kHz tick and a 32.768 kHz tick. A configuration bit picks the time base, and a power-of-two prescaler then divides it. The prescaler divides by 2^N for codes 0 to 10, and every larger code is held at divide-by-1024. At the slowest setting, 1 kHz with divide-by-1024, the counter runs about 67109 seconds before it wraps.

Two compare channels watch the count. Each channel raises a sticky flag when the count reaches its compare value. Each flag drives an interrupt line through its own enable. Only channel A can drive the wake request, so channel B can only interrupt. Software reaches all configuration, compare values, enables, flags and the live count through a small single-cycle register port. Both ticks are single-cycle pulses synchronous to the system clock.

Top module: `wake_sleep_timer`

## Requirements
- R1: The count is 16 bits wide and advances by one on each prescaler step. It wraps from 0xFFFF to 0x0000. It reads back at address 5, and writes to address 5 have no effect.
- R2: Config bit 0 selects the time base: 0 counts `tick_slow_i` (1 kHz) and 1 counts `tick_fast_i` (32.768 kHz). Ticks on the unselected input are ignored.
- R3: With divider code N (config bits 7:4) from 0 to 10, the count advances once per 2^N selected ticks. After a prescaler clear, the first step falls on the 2^N-th tick.
- R4: Divider codes 11 to 15 behave like code 10, giving one step per 1024 selected ticks.
- R5: A config write that changes the source bit or the divider code clears the prescaler. No step occurs in that cycle.
- R6: A compare flag sets in the cycle after a step that makes the count equal its compare value (A at address 1, B at address 2). The flag stays set until software writes 1 to its bit at address 4 (bit 0 for A, bit 1 for B). If a set and a clear fall in the same cycle, the set wins. Flags read back at address 4.
- R7: `irq_a_o` is flag A AND enable bit 0 at address 3. `irq_b_o` is flag B AND enable bit 1 at address 3.
- R8: `wake_o` is flag A AND enable A. A channel B match never asserts it.
- R9: During and after reset, the count, prescaler, flags, enables, compare values, source bit and divider code are all zero.
- R10: Registers read back as written at addresses 0 to 3. Address 0 reads the source bit at bit 0 and the divider code at bits 7:4, with all other bits zero. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_slow_i | input | 1 | Single-cycle 1 kHz time-base tick |
| tick_fast_i | input | 1 | Single-cycle 32.768 kHz time-base tick |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on address) |
| irq_a_o | output | 1 | Channel A interrupt |
| irq_b_o | output | 1 | Channel B interrupt |
| wake_o | output | 1 | Wake request, channel A only |

## Verification
A corrupted prescaler phase does not show up until the next step. That step lands early or late, and the error appears on the count readback up to 1024 selected ticks later. The prescaler-clear and saturation cases are aimed at that window. A wrong count or compare register appears in the next cycle, either on the count readback or as a flag and interrupt edge one cycle off. A stuck or lost flag shows up on `irq_*_o` and `wake_o` in the very cycle it diverges. These outputs are compared against the reference model on every clock.

// File: rtl/wst_pkg.sv
package wst_pkg;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 10;
  localparam int DIV_W   = 4;
  localparam int NUM_CMP = 2;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG    = 3'd0,
    REG_CMP_A  = 3'd1,
    REG_CMP_B  = 3'd2,
    REG_IRQ_EN = 3'd3,
    REG_FLAGS  = 3'd4,
    REG_COUNT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/wst_prescaler.sv
module wst_prescaler #(
  parameter int PRE_W = 10,
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             clr_i,
  output logic             step_o
);
  localparam int MAX_CODE = PRE_W;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] code_eff;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask;

  // codes above the prescaler width saturate
  assign code_eff = (int'(div_code_i) > MAX_CODE) ? DIV_W'(MAX_CODE) : div_code_i;
  assign one_sh   = (PRE_W+1)'(1) << code_eff;
  assign mask     = PRE_W'(one_sh - (PRE_W+1)'(1));
  assign step_o   = tick_i && !clr_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + PRE_W'(1);
  end

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0)) else $error("prescaler not cleared");

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(pre_q)) else $error("prescaler moved without tick");
endmodule

// File: rtl/wst_counter.sv
module wst_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_nxt_o;
  end

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("count step wrong");

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q)) else $error("count moved without step");
endmodule

// File: rtl/wst_compare.sv
module wst_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic flag_q;
  logic hit;

  assign hit    = step_i && (cnt_nxt_i == cmp_i);
  assign flag_o = flag_q;

  // set beats clear so no match is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assert_match_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q) else $error("match did not set flag");

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q) else $error("flag dropped without clear");

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q) else $error("flag clear ignored");
endmodule

// File: rtl/wake_sleep_timer.sv
module wake_sleep_timer
  import wst_pkg::*;
#(
  parameter int CNT_W = wst_pkg::CNT_W,
  parameter int PRE_W = wst_pkg::PRE_W,
  parameter int DIV_W = wst_pkg::DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              wake_o
);
  localparam int NCMP    = NUM_CMP;
  localparam int DIV_LSB = 4;
  localparam int CH_A    = 0;
  localparam int CH_B    = 1;

  logic                       src_q;
  logic [DIV_W-1:0]           div_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [NCMP-1:0]            en_q;
  logic [NCMP-1:0]            flag;
  logic [NCMP-1:0]            flag_clr;
  logic [NCMP-1:0]            irq;
  logic                       tick_sel;
  logic                       cfg_chg;
  logic                       step;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           cnt_nxt;

  assign tick_sel = src_q ? tick_fast_i : tick_slow_i;
  assign cfg_chg  = reg_we_i && (reg_addr_i == REG_CFG) &&
                    ((reg_wdata_i[0] != src_q) || (reg_wdata_i[DIV_LSB +: DIV_W] != div_q));
  assign flag_clr = {NCMP{reg_we_i && (reg_addr_i == REG_FLAGS)}} & reg_wdata_i[NCMP-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      div_q <= '0;
      cmp_q <= '0;
      en_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_CFG: begin
          src_q <= reg_wdata_i[0];
          div_q <= reg_wdata_i[DIV_LSB +: DIV_W];
        end
        REG_CMP_A:  cmp_q[CH_A] <= reg_wdata_i;
        REG_CMP_B:  cmp_q[CH_B] <= reg_wdata_i;
        REG_IRQ_EN: en_q <= reg_wdata_i[NCMP-1:0];
        default: ;
      endcase
    end
  end

  wst_prescaler #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_sel),
    .div_code_i (div_q),
    .clr_i      (cfg_chg),
    .step_o     (step)
  );

  wst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    wst_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step),
      .cnt_nxt_i (cnt_nxt),
      .cmp_i     (cmp_q[g]),
      .clr_i     (flag_clr[g]),
      .flag_o    (flag[g])
    );
    assign irq[g] = flag[g] & en_q[g];
  end

  assign irq_a_o = irq[CH_A];
  assign irq_b_o = irq[CH_B];
  assign wake_o  = irq[CH_A];

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CFG: begin
        reg_rdata_o[0]                 = src_q;
        reg_rdata_o[DIV_LSB +: DIV_W]  = div_q;
      end
      REG_CMP_A:  reg_rdata_o = cmp_q[CH_A];
      REG_CMP_B:  reg_rdata_o = cmp_q[CH_B];
      REG_IRQ_EN: reg_rdata_o[NCMP-1:0] = en_q;
      REG_FLAGS:  reg_rdata_o[NCMP-1:0] = flag;
      REG_COUNT:  reg_rdata_o = cnt;
      default: ;
    endcase
  end

  assert_no_step_on_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> $stable(cnt)) else $error("count stepped on config change");

  assert_wake_only_a_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> flag[CH_A]) else $error("wake without channel A flag");
endmodule

// File: tb/tb_wake_sleep_timer.sv
module tb_wake_sleep_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts = 1'b0, tf = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        irq_a, irq_b, wake;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int m_cnt = 0, m_pre = 0, m_src = 0, m_div = 0;
  int m_cmpa = 0, m_cmpb = 0, m_en = 0, m_fa = 0, m_fb = 0;

  always #10 clk = ~clk;

  wake_sleep_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(ts), .tick_fast_i(tf),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .irq_a_o(irq_a), .irq_b_o(irq_b), .wake_o(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int a);
    case (a)
      0: return 32'(m_src | (m_div << 4));
      1: return 32'(m_cmpa);
      2: return 32'(m_cmpb);
      3: return 32'(m_en);
      4: return 32'(m_fa | (m_fb << 1));
      5: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare_all();
    chk((addr == 3'd5) ? "R1" : "R10", 32'(rd), m_read(int'(addr)), "rdata");
    chk("R7", 32'(irq_a), 32'(m_fa & (m_en & 1)), "irq_a");
    chk("R7", 32'(irq_b), 32'(m_fb & ((m_en >> 1) & 1)), "irq_b");
    chk("R8", 32'(wake), 32'(m_fa & (m_en & 1)), "wake");
  endtask

  task automatic model_step();
    int neff, mask, tsel, en, chg, nc, d;
    d     = int'(wd);
    neff  = (m_div > 10) ? 10 : m_div;
    mask  = (1 << neff) - 1;
    tsel  = m_src ? int'(tf) : int'(ts);
    chg   = (we && addr == 3'd0 && ((d & 1) != m_src || ((d >> 4) & 15) != m_div)) ? 1 : 0;
    en    = (tsel && !chg && ((m_pre & mask) == mask)) ? 1 : 0;
    nc    = en ? ((m_cnt + 1) & 16'hffff) : m_cnt;
    if (en && nc == m_cmpa)                 m_fa = 1;
    else if (we && addr == 3'd4 && (d & 1)) m_fa = 0;
    if (en && nc == m_cmpb)                 m_fb = 1;
    else if (we && addr == 3'd4 && (d & 2)) m_fb = 0;
    if (chg)       m_pre = 0;
    else if (tsel) m_pre = (m_pre + 1) % 1024;
    m_cnt = nc;
    if (we) begin
      case (int'(addr))
        0: begin m_src = d & 1; m_div = (d >> 4) & 15; end
        1: m_cmpa = d;
        2: m_cmpb = d;
        3: m_en = d & 3;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(bit s, bit f, bit w, int a, int d);
    ts = s; tf = f; we = w; addr = 3'(a); wd = 16'(d);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rdchk(string tag, int a, int exp);
    cyc(1'b0, 1'b0, 1'b0, a, 0);
    chk(tag, 32'(rd), 32'(exp), $sformatf("read addr %0d", a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset values
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk("R9", 32'(rd), 32'd0, $sformatf("reset read addr %0d", a));
    end
    chk("R9", 32'({irq_a, irq_b, wake}), 32'd0, "reset outputs");
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0);

    // R10: register readback
    wr(1, 20); wr(2, 12); wr(3, 3); wr(0, 16'h31);
    rdchk("R10", 0, 16'h31);
    rdchk("R10", 1, 20);
    rdchk("R10", 2, 12);
    rdchk("R10", 3, 3);
    rdchk("R10", 6, 0);
    wr(0, 16'hff31);
    rdchk("R10", 0, 16'h31);

    // R3 / R2: fast source, divide by 8, slow ticks ignored
    for (int i = 0; i < 80; i++) cyc(i[0], 1, 0, 5, 0);
    rdchk("R3", 5, 10);
    repeat (40) cyc(1, 0, 0, 5, 0);
    rdchk("R2", 5, 10);

    // R6 / R8: channel B match interrupts but never wakes
    repeat (16) cyc(0, 1, 0, 5, 0);
    rdchk("R6", 4, 2);
    chk("R7", 32'(irq_b), 32'd1, "irq_b after B match");
    chk("R8", 32'(wake), 32'd0, "wake after B match");

    // R8: channel A wakes
    wr(1, 14);
    repeat (16) cyc(0, 1, 0, 5, 0);
    chk("R8", 32'(wake), 32'd1, "wake after A match");
    chk("R7", 32'(irq_a), 32'd1, "irq_a after A match");
    repeat (40) cyc(0, 1, 0, 5, 0);
    rdchk("R6", 4, 3);
    rdchk("R1", 5, 19);
    wr(4, 1);
    chk("R8", 32'(wake), 32'd0, "wake after clear A");
    rdchk("R6", 4, 2);
    wr(4, 2);
    rdchk("R6", 4, 0);

    // R5: config change clears prescaler
    repeat (5) cyc(0, 1, 0, 5, 0);
    wr(0, 16'h21);
    repeat (3) cyc(0, 1, 0, 5, 0);
    rdchk("R5", 5, 19);
    cyc(0, 1, 0, 5, 0);
    rdchk("R5", 5, 20);

    // R4: saturated codes divide by 1024 on slow source
    wr(0, 16'hf0);
    repeat (1023) cyc(1, 1, 0, 5, 0);
    rdchk("R4", 5, 20);
    cyc(1, 0, 0, 5, 0);
    rdchk("R4", 5, 21);
    repeat (1024) cyc(1, 0, 0, 5, 0);
    rdchk("R4", 5, 22);
    wr(0, 16'ha0);
    repeat (1024) cyc(1, 0, 0, 5, 0);
    rdchk("R4", 5, 23);

    // R7: enable gates the interrupt, flag still sets
    wr(3, 0); wr(0, 16'h01); wr(1, 25);
    repeat (2) cyc(0, 1, 0, 5, 0);
    chk("R7", 32'({irq_a, wake}), 32'd0, "disabled irq_a/wake");
    rdchk("R6", 4, 1);
    wr(3, 1);
    chk("R7", 32'(irq_a), 32'd1, "irq_a after enable");
    chk("R8", 32'(wake), 32'd1, "wake after enable");
    wr(4, 3);

    // R1: count write ignored, wrap
    wr(5, 16'h1234);
    rdchk("R1", 5, 25);
    wr(2, 2);
    for (int i = 0; i < 65536 - 25 + 2; i++) cyc(0, 1, 0, 5, 0);
    rdchk("R1", 5, 2);
    rdchk("R6", 4, 2);

    // R6: set wins over same-cycle clear
    wr(4, 2); wr(1, 5);
    repeat (2) cyc(0, 1, 0, 5, 0);
    cyc(0, 1, 1, 4, 1);
    rdchk("R6", 4, 1);
    rdchk("R1", 5, 5);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      if (($urandom % 16) == 0) begin
        a = int'($urandom % 6);
        if (a == 0) d = int'(($urandom % 2) | (($urandom % 16) << 4));
        else if (a == 1 || a == 2) d = int'($urandom % 64);
        else d = int'($urandom % 65536);
        cyc(1'($urandom), 1'($urandom), 1'b1, a, d);
      end else begin
        cyc(1'($urandom), 1'($urandom), 1'b0, int'($urandom % 8), 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule